// File: doc/BRIEF.md
# Oversampled Serial Receiver with Parity Check

This block turns an asynchronous serial line back into data words. An enable pulse arrives at sixteen times the bit rate. The block waits for a falling edge on the idle-high line. It confirms the start bit at its centre and then samples each later bit at its centre, least significant bit first. The word is 5 to 8 bits long. The receiver uses the same line-format controls as its transmitting partner: word length, parity enable, even/odd select and forced ("stuck") parity.

After the last data bit, the receiver optionally takes a parity bit and compares it with the value it expects. It then samples one stop bit and returns to idle at once. A transmitter configured for longer stop periods is received correctly, because the receiver needs only one stop bit. Each frame ends with a one-cycle valid pulse. The pulse carries the word, a parity-error flag and a framing-error flag, all in the same cycle.

Top module: `uart_rx_parity`

## Requirements
- R1: After synchronous reset, `rx_data` is 0 and `rx_valid`, `par_err` and `frm_err` are 0.
- R2: A low level on `rxd` is taken as a start bit only if it is still low at the centre of the start bit, 8 ticks after the falling edge. A shorter low pulse produces no frame, and the receiver returns to waiting for an edge.
- R3: Data bits arrive least significant first. `word_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 bits. Bits above the selected length read as 0 in `rx_data`.
- R4: Each received frame gives exactly one `rx_valid` pulse, one clock cycle wide. `par_err` and `frm_err` for that frame are valid in the same cycle as the pulse.
- R5: With `par_en` = 0, no parity bit is expected: the stop bit follows the last data bit directly, and `par_err` is 0.
- R6: With `par_en` = 1 and `par_stick` = 0, the expected parity makes the count of ones over the data bits and the parity bit odd when `par_even` = 0 and even when `par_even` = 1. Examples: 0x60 odd gives 1, 0x60 even gives 0, 0x57 even gives 1. A received bit that differs from the expected value sets `par_err`.
- R7: With `par_en` = 1 and `par_stick` = 1, the expected parity bit is the inverse of `par_even`, whatever the data. A mismatch sets `par_err`.
- R8: One stop bit is enough. A new start bit that follows a single stop bit immediately is received as the next frame.
- R9: If the stop-bit sample is low, `frm_err` is 1 and the word is still delivered with `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high, asynchronous |
| word_len | input | 2 | Data bits minus 5 (0..3 gives 5..8 bits) |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | Even parity select; in stuck mode its inverse is the expected bit |
| par_stick | input | 1 | Forces the expected parity bit to a fixed value |
| rx_data | output | DATA_W | Received word, zero-extended |
| rx_valid | output | 1 | One-cycle strobe for a completed frame |
| par_err | output | 1 | Parity mismatch for the frame just delivered |
| frm_err | output | 1 | Stop bit sampled low for the frame just delivered |

## Verification
The assertions assume that `word_len`, `par_en`, `par_even` and `par_stick` stay constant while a frame is in flight. They also assume that `tick16` is a single-cycle pulse no faster than every other clock. The bench changes the line format only between frames, while the line is idle. It derives `tick16` from a fixed clock divider. It changes `rxd` only on whole bit boundaries of that divider, except in the shortened-start and low-stop scenarios, where the low period ends well away from any sampling centre.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_par_calc.sv
module rx_par_calc #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] word,      // unused upper bits already zero
  input  logic              par_even,
  input  logic              par_stick,
  output logic              exp_bit
);
  logic ones_odd;

  assign ones_odd = ^word;
  // normal mode: even select -> bit equals data XOR; odd select -> its inverse
  assign exp_bit  = par_stick ? ~par_even : (ones_odd ^ ~par_even);
endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rxd,
  input  logic [1:0]        word_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              par_err,
  output logic              frm_err
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVS - 1);

  rx_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  bit_idx;
  logic [IDX_W:0]    last_idx;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;
  logic              rxd_s;
  logic              exp_bit;
  logic              at_centre;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd),
    .dout (rxd_s)
  );

  rx_par_calc #(.DATA_W(DATA_W)) u_par (
    .word      (shreg),
    .par_even  (par_even),
    .par_stick (par_stick),
    .exp_bit   (exp_bit)
  );

  assign last_idx  = (IDX_W + 1)'(word_len) + (IDX_W + 1)'(4);
  assign at_centre = tick16 && (cnt == LAST_TICK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      par_bit  <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tick16 && !(state == RX_IDLE) && !at_centre) cnt <= cnt + 1'b1;
      unique case (state)
        RX_IDLE: begin
          if (tick16 && !rxd_s) begin
            state <= RX_START;
            cnt   <= '0;
            shreg <= '0;
          end
        end
        RX_START: begin
          if (tick16 && cnt == MID_TICK) begin
            cnt     <= '0;
            bit_idx <= '0;
            state   <= rxd_s ? RX_IDLE : RX_DATA;
          end
        end
        RX_DATA: begin
          if (at_centre) begin
            cnt            <= '0;
            shreg[bit_idx] <= rxd_s;
            bit_idx        <= bit_idx + 1'b1;
            if ({1'b0, bit_idx} == last_idx)
              state <= par_en ? RX_PAR : RX_STOP;
          end
        end
        RX_PAR: begin
          if (at_centre) begin
            cnt     <= '0;
            par_bit <= rxd_s;
            state   <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (at_centre) begin
            cnt      <= '0;
            rx_data  <= shreg;
            rx_valid <= 1'b1;
            frm_err  <= ~rxd_s;
            par_err  <= par_en && (par_bit != exp_bit);
            state    <= RX_IDLE;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R4: strobe lasts a single cycle
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R9: a delivered word always comes out of the stop-bit sample
  a_r9_valid_from_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_valid) |-> $past(state) == RX_STOP);

  // R3: short words leave the upper bits clear
  a_r3_short_word_clean: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && word_len == 2'd0) |-> (rx_data >> 5) == '0);

  // R3: bit index never runs beyond the selected length
  a_r3_idx_range: assert property (@(posedge clk) disable iff (rst)
    (state == RX_DATA) |-> ({1'b0, bit_idx} <= last_idx));

  // R5: no parity error when no parity bit is configured
  a_r5_no_par_err: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !par_en) |-> !par_err);

  // R2: a high sample at the start-bit centre abandons the frame
  a_r2_false_start: assert property (@(posedge clk) disable iff (rst)
    (state == RX_START && tick16 && cnt == MID_TICK && rxd_s) |=> state == RX_IDLE);
endmodule

// File: tb/tb_uart_rx_parity.sv
module tb_uart_rx_parity;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int BIT_CLKS   = 16 * DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] word_len = 2'd3;
  logic       par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, par_err, frm_err;

  int errors = 0, checks = 0, got_n = 0, div_cnt = 0;
  logic [7:0] got_data;
  logic       got_pe, got_fe;
  logic [7:0] hist [0:63];
  bit         done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_rx_parity dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .word_len(word_len),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err), .frm_err(frm_err)
  );

  always @(posedge clk) begin
    div_cnt <= (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
    tick16  <= (div_cnt == DIV - 1);
  end

  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      hist[got_n % 64] = rx_data;
      got_n    = got_n + 1;
      got_data = rx_data;
      got_pe   = par_err;
      got_fe   = frm_err;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic ref_par(input logic [7:0] d, input int nb,
                                   input logic ev, input logic st);
    int ones = 0;
    for (int i = 0; i < nb; i++) ones += d[i];
    if (st) return ~ev;
    return ev ? logic'(ones % 2) : logic'(1 - ones % 2);
  endfunction

  // stop_ok=0 holds the line low through the stop-bit centre, then releases it
  task automatic send(input logic [7:0] d, input int nb, input bit has_par,
                      input logic pbit, input bit stop_ok);
    rxd = 1'b0; wait_clks(BIT_CLKS);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; wait_clks(BIT_CLKS); end
    if (has_par) begin rxd = pbit; wait_clks(BIT_CLKS); end
    if (stop_ok) begin rxd = 1'b1; wait_clks(BIT_CLKS); end
    else begin rxd = 1'b0; wait_clks(BIT_CLKS * 10 / 16); rxd = 1'b1; wait_clks(BIT_CLKS * 6 / 16); end
  endtask

  task automatic set_fmt(input logic [1:0] wl, input logic pe, input logic ev, input logic st);
    word_len = wl; par_en = pe; par_even = ev; par_stick = st;
    wait_clks(BIT_CLKS);
  endtask

  task automatic frame_check(input string req, input logic [7:0] d, input int nb,
                             input bit has_par, input logic pbit, input bit stop_ok,
                             input logic [7:0] exp_d, input logic exp_pe, input logic exp_fe);
    int n0 = got_n;
    send(d, nb, has_par, pbit, stop_ok);
    wait_clks(BIT_CLKS);
    chk({req, " count"}, got_n, n0 + 1);
    chk({req, " data"}, got_data, exp_d);
    chk({req, " par_err"}, got_pe, exp_pe);
    chk({req, " frm_err"}, got_fe, exp_fe);
  endtask

  task automatic t_reset;
    chk("R1 rx_data", rx_data, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 par_err", par_err, 0);
    chk("R1 frm_err", frm_err, 0);
  endtask

  task automatic t_lengths;
    set_fmt(2'd3, 0, 0, 0);
    frame_check("R3 8bit R5 R4", 8'hA5, 8, 0, 0, 1, 8'hA5, 0, 0);
    set_fmt(2'd0, 0, 0, 0);
    frame_check("R3 5bit", 8'hFB, 5, 0, 0, 1, 8'h1B, 0, 0);
    set_fmt(2'd2, 0, 0, 0);
    frame_check("R3 7bit", 8'h4E, 7, 0, 0, 1, 8'h4E, 0, 0);
  endtask

  task automatic t_parity;
    set_fmt(2'd3, 1, 0, 0);
    chk("R6 ref 0x60 odd", ref_par(8'h60, 8, 0, 0), 1);
    frame_check("R6 0x60 odd", 8'h60, 8, 1, 1'b1, 1, 8'h60, 0, 0);
    frame_check("R6 0x57 odd wrong", 8'h57, 8, 1, 1'b1, 1, 8'h57, 1, 0);
    set_fmt(2'd3, 1, 1, 0);
    frame_check("R6 0x60 even", 8'h60, 8, 1, 1'b0, 1, 8'h60, 0, 0);
    frame_check("R6 0x57 even", 8'h57, 8, 1, 1'b1, 1, 8'h57, 0, 0);
    set_fmt(2'd1, 1, 0, 0);
    frame_check("R6 6bit odd", 8'h2D, 6, 1, ref_par(8'h2D, 6, 0, 0), 1, 8'h2D, 0, 0);
  endtask

  task automatic t_stick;
    set_fmt(2'd3, 1, 1, 1);
    frame_check("R7 stick ev1 ok", 8'h57, 8, 1, 1'b0, 1, 8'h57, 0, 0);
    frame_check("R7 stick ev1 bad", 8'h60, 8, 1, 1'b1, 1, 8'h60, 1, 0);
    set_fmt(2'd3, 1, 0, 1);
    frame_check("R7 stick ev0 ok", 8'h60, 8, 1, 1'b1, 1, 8'h60, 0, 0);
  endtask

  task automatic t_false_start;
    int n0;
    set_fmt(2'd3, 0, 0, 0);
    n0 = got_n;
    rxd = 1'b0; wait_clks(4 * DIV); rxd = 1'b1;
    wait_clks(BIT_CLKS * 12);
    chk("R2 glitch no frame", got_n, n0);
    frame_check("R2 after glitch", 8'h3C, 8, 0, 0, 1, 8'h3C, 0, 0);
  endtask

  task automatic t_back_to_back;
    int n0;
    set_fmt(2'd3, 1, 1, 0);
    n0 = got_n;
    send(8'h81, 8, 1, ref_par(8'h81, 8, 1, 0), 1);
    send(8'h7E, 8, 1, ref_par(8'h7E, 8, 1, 0), 1);
    wait_clks(BIT_CLKS);
    chk("R8 two frames", got_n, n0 + 2);
    chk("R8 first word", hist[n0 % 64], 8'h81);
    chk("R8 second word", got_data, 8'h7E);
    chk("R8 no par_err", got_pe, 0);
  endtask

  task automatic t_framing;
    set_fmt(2'd3, 0, 0, 0);
    frame_check("R9 low stop", 8'hC3, 8, 0, 0, 0, 8'hC3, 0, 1);
    frame_check("R9 cleared next", 8'h12, 8, 0, 0, 1, 8'h12, 0, 0);
  endtask

  initial begin
    wait_clks(5);
    t_reset;
    rst = 1'b0;
    wait_clks(BIT_CLKS);
    t_lengths;
    t_parity;
    t_stick;
    t_false_start;
    t_back_to_back;
    t_framing;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule